// File: doc/BRIEF.md
# Programmable PWM Timer

This block is a general-purpose timer core on a single clock domain. A programmable prescaler turns the system clock into a one-cycle tick enable, one tick every (divide setting + 1) enabled cycles. The main counter moves only on that tick. Its turning point is set by a reload limit, and it can count up, count down or run centre-aligned, rising and then falling. Each tick that leaves a turning value raises a one-cycle event flag. A compare threshold drives a PWM level that is high while the count is below the threshold.

Settings come in through a plain write strobe that is always accepted, so there is no back-pressure and no valid/ready handshake. A write made while the counter is stopped takes effect at once and restarts the count. A write made while the counter runs is held in shadow registers and applied only when the current period ends, so a running period is never cut short.

Top module: `pwm_timer`

## Requirements
- R1: While reset is asserted and just after it is released, `count` is 0, both event flags are low, `pwm_out` is low, the mode is count-up and the divide, limit and threshold settings are all 0.
- R2: While `cnt_en` is high, the counter moves once every (active divide value + 1) clock cycles. A divide value of 0 moves it on every cycle. The first move after a stopped write comes on the (divide + 1)-th enabled cycle.
- R3: In count-up mode (`cfg_mode` 2'b00, with 2'b11 treated the same), a tick steps the count from 0 up to the limit. The tick that leaves the limit sets the count to 0 and raises `ovf_pulse` for one cycle, so a limit of N-1 gives a period of N ticks.
- R4: In count-down mode (`cfg_mode` 2'b01), a tick steps the count down to 0. The tick that leaves 0 reloads the count with the limit that becomes active at that boundary and raises `udf_pulse` for one cycle.
- R5: In centre-aligned mode (`cfg_mode` 2'b10), the count rises from 0 to the limit and then falls back to 0, and each turning value is held for one tick only. The tick that leaves the limit raises `ovf_pulse`, and the tick that leaves 0 on the way down raises `udf_pulse` (the count then shows 1 when the new limit is at least 1). The two flags are never high together.
- R6: `pwm_out` is high exactly when `count` is below the active threshold. A threshold of 0 holds it low, and a threshold above the limit holds it high.
- R7: Divide, limit and threshold values written while `cnt_en` is high take effect only at the end of the period: at the overflow in count-up mode and at the underflow in count-down and centre-aligned modes. Until then, `count` stays within the limit that was active when the period began.
- R8: A write while `cnt_en` is low makes all four settings active at once. It sets `count` to the new limit in count-down mode and to 0 otherwise, and restarts the centre-aligned direction as rising.
- R9: The mode field of a write made while `cnt_en` is high is ignored. Counting goes on in the mode that was active before the write.
- R10: While `cnt_en` is low and no write occurs, `count` holds, both event flags are low, and the prescaler phase restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Run enable for prescaler and counter |
| cfg_we | input | 1 | Settings write strobe |
| cfg_psc | input | PSC_W | Divide setting (divides by value + 1) |
| cfg_arr | input | CNT_W | Reload limit |
| cfg_cmp | input | CNT_W | PWM threshold |
| cfg_mode | input | 2 | Counting mode: 00 up, 01 down, 10 centre, 11 up |
| count | output | CNT_W | Current counter value |
| ovf_pulse | output | 1 | One-cycle flag for a tick leaving the upper turning value |
| udf_pulse | output | 1 | One-cycle flag for a tick leaving zero in down or centre mode |
| pwm_out | output | 1 | PWM level, high while count is below the threshold |

## Verification
A tick that the prescaler grants in one cycle moves `count` and sets the event flags at the next rising edge. The effect of a stopped write also shows right after that edge, and `pwm_out` follows `count` in the same cycle with no extra register. The bench drives inputs only between edges and samples every output 2 ns after each rising edge. It steps a reference model at that same edge, so each expected value is due exactly one register stage after the stimulus that caused it. Buffered writes are checked across whole periods, so the old limit must hold until the boundary cycle and the new one must show right after it.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;

  // Counting mode, as carried by the two-bit mode field.
  typedef enum logic [1:0] {
    MODE_UP     = 2'b00,
    MODE_DOWN   = 2'b01,
    MODE_CENTER = 2'b10,
    MODE_UP_ALT = 2'b11
  } cnt_mode_e;

  // Direction of travel in centre-aligned mode.
  typedef enum logic {
    DIR_RISE = 1'b0,
    DIR_FALL = 1'b1
  } cnt_dir_e;

endpackage

// File: rtl/pwm_timer_prescaler.sv
`timescale 1ns/1ps
module pwm_timer_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PSC_W-1:0] lim_i,
  output logic             tick_o
);

  logic [PSC_W-1:0] phase_q;

  // Tick on the cycle where the phase reaches the limit: one per lim+1 cycles.
  assign tick_o = run_i && (phase_q >= lim_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!run_i || tick_o) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_timer_shadow.sv
`timescale 1ns/1ps
module pwm_timer_shadow
  import pwm_timer_pkg::*;
#(
  parameter int PSC_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic [PSC_W-1:0] wr_psc_i,
  input  logic [CNT_W-1:0] wr_arr_i,
  input  logic [CNT_W-1:0] wr_cmp_i,
  input  cnt_mode_e        wr_mode_i,
  input  logic             boundary_i,
  output logic [PSC_W-1:0] psc_o,
  output logic [CNT_W-1:0] arr_o,
  output logic [CNT_W-1:0] cmp_o,
  output cnt_mode_e        mode_o,
  output logic [CNT_W-1:0] arr_next_o
);

  logic [PSC_W-1:0] pend_psc_q, act_psc_q;
  logic [CNT_W-1:0] pend_arr_q, act_arr_q;
  logic [CNT_W-1:0] pend_cmp_q, act_cmp_q;
  cnt_mode_e        act_mode_q;
  logic             direct_ld;

  assign direct_ld = wr_i && !run_i;

  // Pending copy: follows every write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_psc_q <= '0;
      pend_arr_q <= '0;
      pend_cmp_q <= '0;
    end else if (wr_i) begin
      pend_psc_q <= wr_psc_i;
      pend_arr_q <= wr_arr_i;
      pend_cmp_q <= wr_cmp_i;
    end
  end

  // Active copy: direct while stopped, otherwise only at a period boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_psc_q  <= '0;
      act_arr_q  <= '0;
      act_cmp_q  <= '0;
      act_mode_q <= MODE_UP;
    end else if (direct_ld) begin
      act_psc_q  <= wr_psc_i;
      act_arr_q  <= wr_arr_i;
      act_cmp_q  <= wr_cmp_i;
      act_mode_q <= wr_mode_i;
    end else if (boundary_i) begin
      act_psc_q  <= pend_psc_q;
      act_arr_q  <= pend_arr_q;
      act_cmp_q  <= pend_cmp_q;
    end
  end

  assign psc_o      = act_psc_q;
  assign arr_o      = act_arr_q;
  assign cmp_o      = act_cmp_q;
  assign mode_o     = act_mode_q;
  assign arr_next_o = pend_arr_q;

endmodule

// File: rtl/pwm_timer_core.sv
`timescale 1ns/1ps
module pwm_timer_core
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  cnt_mode_e        mode_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic [CNT_W-1:0] arr_next_i,
  input  logic             load_i,
  input  cnt_mode_e        load_mode_i,
  input  logic [CNT_W-1:0] load_arr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             udf_o,
  output logic             boundary_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  cnt_dir_e         dir_q, dir_d;
  logic             ovf_q, ovf_d, udf_q, udf_d, bnd;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    ovf_d = 1'b0;
    udf_d = 1'b0;
    bnd   = 1'b0;
    if (load_i) begin
      cnt_d = (load_mode_i == MODE_DOWN) ? load_arr_i : '0;
      dir_d = DIR_RISE;
    end else if (tick_i) begin
      case (mode_i)
        MODE_DOWN: begin
          if (cnt_q == '0) begin
            cnt_d = arr_next_i;
            udf_d = 1'b1;
            bnd   = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        MODE_CENTER: begin
          if (dir_q == DIR_RISE) begin
            if (cnt_q >= arr_i) begin
              cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
              dir_d = DIR_FALL;
              ovf_d = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            if (cnt_q == '0) begin
              cnt_d = (arr_next_i == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
              dir_d = DIR_RISE;
              udf_d = 1'b1;
              bnd   = 1'b1;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        default: begin
          if (cnt_q >= arr_i) begin
            cnt_d = '0;
            ovf_d = 1'b1;
            bnd   = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_RISE;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      ovf_q <= ovf_d;
      udf_q <= udf_d;
    end
  end

  assign count_o    = cnt_q;
  assign ovf_o      = ovf_q;
  assign udf_o      = udf_q;
  assign boundary_o = bnd;

endmodule

// File: rtl/pwm_timer_compare.sv
`timescale 1ns/1ps
module pwm_timer_compare #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             pwm_o
);

  // Both operands are registers, so the level changes only after a clock edge.
  assign pwm_o = (count_i < thr_i);

endmodule

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int PSC_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             cfg_we,
  input  logic [PSC_W-1:0] cfg_psc,
  input  logic [CNT_W-1:0] cfg_arr,
  input  logic [CNT_W-1:0] cfg_cmp,
  input  logic [1:0]       cfg_mode,
  output logic [CNT_W-1:0] count,
  output logic             ovf_pulse,
  output logic             udf_pulse,
  output logic             pwm_out
);

  logic [PSC_W-1:0] psc_act;
  logic [CNT_W-1:0] arr_act, cmp_act, arr_pend;
  cnt_mode_e        mode_act, mode_wr;
  logic             tick, boundary, load_now;

  assign mode_wr  = cnt_mode_e'(cfg_mode);
  assign load_now = cfg_we && !cnt_en;

  pwm_timer_shadow #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (cnt_en),
    .wr_i       (cfg_we),
    .wr_psc_i   (cfg_psc),
    .wr_arr_i   (cfg_arr),
    .wr_cmp_i   (cfg_cmp),
    .wr_mode_i  (mode_wr),
    .boundary_i (boundary),
    .psc_o      (psc_act),
    .arr_o      (arr_act),
    .cmp_o      (cmp_act),
    .mode_o     (mode_act),
    .arr_next_o (arr_pend)
  );

  pwm_timer_prescaler #(.PSC_W(PSC_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (cnt_en),
    .lim_i  (psc_act),
    .tick_o (tick)
  );

  pwm_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .mode_i      (mode_act),
    .arr_i       (arr_act),
    .arr_next_i  (arr_pend),
    .load_i      (load_now),
    .load_mode_i (mode_wr),
    .load_arr_i  (cfg_arr),
    .count_o     (count),
    .ovf_o       (ovf_pulse),
    .udf_o       (udf_pulse),
    .boundary_o  (boundary)
  );

  pwm_timer_compare #(.CNT_W(CNT_W)) u_cmp (
    .count_i (count),
    .thr_i   (cmp_act),
    .pwm_o   (pwm_out)
  );

endmodule

// File: rtl/pwm_timer_sva.sv
`timescale 1ns/1ps
module pwm_timer_sva
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             cfg_we,
  input logic [CNT_W-1:0] count,
  input logic             ovf_pulse,
  input logic             udf_pulse,
  input cnt_mode_e        mode_act,
  input logic [CNT_W-1:0] arr_act
);

  // R10: stopped with no write keeps the count and the flags quiet.
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cfg_we) |=> ($stable(count) && !ovf_pulse && !udf_pulse));

  // R5: the two event flags never coincide.
  p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_pulse && udf_pulse));

  // R3: an overflow in count-up mode leaves the count at zero.
  p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && mode_act != MODE_DOWN && mode_act != MODE_CENTER) |-> (count == '0));

  // R4: an underflow in count-down mode reloads the active limit.
  p_down_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_pulse && mode_act == MODE_DOWN) |-> (count == arr_act));

  // R5: the bottom turning value is held for one tick only.
  p_center_bottom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_pulse && mode_act == MODE_CENTER && arr_act != '0) |-> (count == 1));

  // R7: the count never exceeds the limit that is active.
  p_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= arr_act);

endmodule

bind pwm_timer pwm_timer_sva #(.CNT_W(CNT_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_en    (cnt_en),
  .cfg_we    (cfg_we),
  .count     (count),
  .ovf_pulse (ovf_pulse),
  .udf_pulse (udf_pulse),
  .mode_act  (mode_act),
  .arr_act   (arr_act)
);

// File: tb/pwm_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_timer_tb_top;

  localparam int PSC_W = 16;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cnt_en;
  logic             cfg_we;
  logic [PSC_W-1:0] cfg_psc;
  logic [CNT_W-1:0] cfg_arr;
  logic [CNT_W-1:0] cfg_cmp;
  logic [1:0]       cfg_mode;
  logic [CNT_W-1:0] count;
  logic             ovf_pulse, udf_pulse, pwm_out;

  always #5 clk = ~clk;

  pwm_timer #(.PSC_W(PSC_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cfg_we(cfg_we),
    .cfg_psc(cfg_psc), .cfg_arr(cfg_arr), .cfg_cmp(cfg_cmp), .cfg_mode(cfg_mode),
    .count(count), .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse), .pwm_out(pwm_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference model state, built from the requirements.
  int m_cnt, m_dir, m_ph;
  int a_psc, a_arr, a_cmp, a_mode;
  int p_psc, p_arr, p_cmp;
  bit m_ovf, m_udf;

  task automatic check(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // One rising edge of the model, using the inputs present at that edge.
  task automatic model_edge();
    bit tick, bnd;
    m_ovf = 0; m_udf = 0; bnd = 0;
    if (!cnt_en) begin
      m_ph = 0;
      if (cfg_we) begin
        p_psc = cfg_psc; p_arr = cfg_arr; p_cmp = cfg_cmp;
        a_psc = cfg_psc; a_arr = cfg_arr; a_cmp = cfg_cmp; a_mode = cfg_mode;
        m_cnt = (cfg_mode == 2'b01) ? int'(cfg_arr) : 0;
        m_dir = 0;
      end
    end else begin
      tick = (m_ph >= a_psc);
      m_ph = tick ? 0 : m_ph + 1;
      if (tick) begin
        case (a_mode)
          1: if (m_cnt == 0) begin m_cnt = p_arr; m_udf = 1; bnd = 1; end
             else m_cnt--;
          2: if (m_dir == 0) begin
               if (m_cnt >= a_arr) begin
                 m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; m_dir = 1; m_ovf = 1;
               end else m_cnt++;
             end else begin
               if (m_cnt == 0) begin
                 m_cnt = (p_arr == 0) ? 0 : 1; m_dir = 0; m_udf = 1; bnd = 1;
               end else m_cnt--;
             end
          default: if (m_cnt >= a_arr) begin m_cnt = 0; m_ovf = 1; bnd = 1; end
                   else m_cnt++;
        endcase
      end
      if (bnd) begin a_psc = p_psc; a_arr = p_arr; a_cmp = p_cmp; end
      if (cfg_we) begin p_psc = cfg_psc; p_arr = cfg_arr; p_cmp = cfg_cmp; end
    end
  endtask

  function automatic int pack_out(int c, bit o, bit u, bit p);
    return (c << 3) | (int'(o) << 2) | (int'(u) << 1) | int'(p);
  endfunction

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    #2;
    check(tag, pack_out(count, ovf_pulse, udf_pulse, pwm_out),
          pack_out(m_cnt, m_ovf, m_udf, m_cnt < a_cmp), "{count,ovf,udf,pwm}");
  endtask

  task automatic stopped_cfg(int psc, int arr, int cmp, int mode, string tag);
    cnt_en = 0; cfg_we = 1;
    cfg_psc = PSC_W'(psc); cfg_arr = CNT_W'(arr); cfg_cmp = CNT_W'(cmp); cfg_mode = 2'(mode);
    step(tag);
    cfg_we = 0;
  endtask

  task automatic run(int n, string tag);
    cnt_en = 1;
    for (int i = 0; i < n; i++) step(tag);
  endtask

  function automatic string mode_tag(int md);
    return (md == 1) ? "R4" : (md == 2) ? "R5" : "R3";
  endfunction

  // Watchdog: an expired run counts as a failed check.
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; cnt_en = 0; cfg_we = 0;
    cfg_psc = '0; cfg_arr = '0; cfg_cmp = '0; cfg_mode = '0;
    m_cnt = 0; m_dir = 0; m_ph = 0; m_ovf = 0; m_udf = 0;
    a_psc = 0; a_arr = 0; a_cmp = 0; a_mode = 0; p_psc = 0; p_arr = 0; p_cmp = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", count, 0, "count in reset");
    check("R1", {ovf_pulse, udf_pulse, pwm_out}, 0, "flags/pwm in reset");
    #1 rst_n = 1;
    step("R1");

    // Count-up, no division, period of 5 ticks.
    stopped_cfg(0, 4, 2, 0, "R8");
    check("R8", count, 0, "count after stopped write");
    run(5, "R3");
    check("R3", {count, ovf_pulse}, 1, "wrap to 0 with overflow");
    run(7, "R3");

    // Divide by 3.
    stopped_cfg(2, 3, 1, 0, "R8");
    run(4, "R2");
    check("R2", count, 1, "count after 4 enabled cycles at divide 3");
    run(20, "R2");

    // Count-down.
    stopped_cfg(1, 3, 2, 1, "R8");
    check("R8", count, 3, "down start value");
    run(16, "R4");

    // Centre-aligned.
    stopped_cfg(0, 3, 2, 2, "R8");
    run(4, "R5");
    check("R5", {count, ovf_pulse}, 5, "top turn: count 2 with overflow");
    run(12, "R5");

    // Threshold extremes.
    stopped_cfg(0, 4, 0, 0, "R6");
    run(10, "R6");
    stopped_cfg(0, 4, 5, 0, "R6");
    run(10, "R6");
    check("R6", pwm_out, 1, "threshold above limit holds high");

    // Buffered write while running.
    stopped_cfg(0, 5, 3, 0, "R8");
    run(2, "R7");
    cfg_we = 1; cfg_arr = 2; cfg_cmp = 1;
    step("R7");
    cfg_we = 0;
    check("R7", count, 3, "old limit still running");
    run(3, "R7");
    check("R7", {count, ovf_pulse}, 1, "wrap at old limit 5");
    run(8, "R7");

    // Mode field ignored while running.
    cfg_we = 1; cfg_mode = 2'b01; cfg_arr = 2;
    step("R9");
    cfg_we = 0;
    run(9, "R9");
    check("R9", udf_pulse, 0, "no underflow in kept up mode");

    // Hold while stopped.
    cnt_en = 0;
    for (int i = 0; i < 5; i++) step("R10");
    run(6, "R10");

    // Random phase.
    for (int k = 0; k < 30; k++) begin
      stopped_cfg($urandom % 4, $urandom % 10, $urandom % 12, $urandom % 4, "R8");
      for (int c = 0; c < 60; c++) begin
        cnt_en = (($urandom % 8) != 0);
        cfg_we = (($urandom % 12) == 0);
        if (cfg_we) begin
          cfg_psc = PSC_W'($urandom % 4); cfg_arr = CNT_W'($urandom % 10);
          cfg_cmp = CNT_W'($urandom % 12); cfg_mode = 2'($urandom % 4);
        end
        step(mode_tag(a_mode));
      end
      cfg_we = 0;
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule